// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that keeps running after it has been started. Software reaches it through a small register port with four word locations: a key location, a prescaler location, a reload location and a status location. Special 16-bit codes written to the key location do three things. One code opens the prescaler and reload registers for writing. One code refreshes the countdown. One code starts the timer. After the timer starts, no register write can stop it. Only the block reset returns it to the stopped state.

A slow time base reaches the block as a one-cycle `tick` enable on the system clock. A prescaler divides the ticks by a power of two. The divided steps decrement a 12-bit down-counter. If software does not refresh the counter before it runs out, the block raises `wdt_reset_req` for one system clock cycle. It then reloads the counter and keeps counting. Another part of the chip distributes the actual system reset.

Top module: `wdt_indep`

## Requirements
- R1: After reset the prescaler field reads 0, the reload register reads 0xFFF, the counter reads 0xFFF, the timer is stopped, configuration is locked and `wdt_reset_req` is low.
- R2: Writing 0x5555 to the key location (address 0) unlocks configuration. While unlocked, a write to address 1 stores data bits 2:0 as the prescaler field, and a write to address 2 stores data bits 11:0 as the reload value. Higher data bits are discarded, and the new value reads back from the next cycle.
- R3: Writing any key value other than 0x5555, the refresh and start codes included, locks configuration again. A write to address 1 or 2 while locked leaves the stored value unchanged.
- R4: Writing 0xCCCC to the key location while stopped starts the timer, loads the counter from the reload register and clears the prescaler phase. Writing 0xCCCC while already running leaves the counter unchanged.
- R5: Once running, the timer stays running whatever is written to any location, until the block reset.
- R6: Writing 0xAAAA to the key location loads the counter from the reload register and clears the prescaler phase. This happens whether the timer is running or not.
- R7: While running, the counter decrements once every D ticks, where D = min(4·2^p, 256) and p is the prescaler field. Cycles with `tick` low do not advance it.
- R8: After a start or refresh with reload value L, the (D·L)-th tick raises `wdt_reset_req` for exactly one cycle, in the cycle after the clock edge that samples that tick. The counter then reloads and the timer keeps running. A reload value of 0 behaves as 1.
- R9: Reading address 3 returns the running flag in bit 15, the unlock flag in bit 14 and the counter in bits 11:0, with all other bits zero. Reading address 0 returns zero.
- R10: While stopped, ticks neither change the counter nor raise `wdt_reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable from the slow time base |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 key, 1 prescaler, 2 reload, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The faults that matter here all stay hidden inside the block: a prescaler phase that was not cleared, a lock flag left open, or a counter loaded off by one. None of them shows up at once. The counter and flags can be read through the status location in the cycle after any write. Prescaler faults only show up as a reset request arriving a few ticks early or late, which can be up to D·L ticks after the fault. For this reason every timeout check counts ticks from the refresh to the request and compares the total exactly. A lock fault shows up at the next readback of a configuration register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_PRESC  = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STATUS = 2'd3
    } wdt_addr_e;

    // log2 of the divide ratio: prescaler field plus a base, clipped at a maximum
    function automatic int unsigned div_log2(input int unsigned prer,
                                             input int unsigned base_log,
                                             input int unsigned max_log);
        int unsigned lg;
        lg = prer + base_log;
        if (lg > max_log) lg = max_log;
        return lg;
    endfunction

endpackage

// File: rtl/wdt_keyctl.sv
module wdt_keyctl
    import wdt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PRER_W   = 3,
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                unlocked,
    output logic                running,
    output logic [PRER_W-1:0]   prer,
    output logic [RELOAD_W-1:0] reload,
    output logic                refresh,
    output logic                start_load
);

    typedef struct packed {
        logic                unlocked;
        logic                running;
        logic [PRER_W-1:0]   prer;
        logic [RELOAD_W-1:0] reload;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic key_wr;
    logic [KEY_W-1:0] key_val;

    assign key_wr  = wr && (addr == ADDR_KEY);
    assign key_val = KEY_W'(wdata);

    always_comb begin
        ctl_d      = ctl_q;
        refresh    = 1'b0;
        start_load = 1'b0;
        if (key_wr) begin
            // any key other than the unlock code closes configuration
            ctl_d.unlocked = (key_val == KEY_UNLOCK);
            if (key_val == KEY_REFRESH) begin
                refresh = 1'b1;
            end
            if (key_val == KEY_START) begin
                start_load    = !ctl_q.running;
                ctl_d.running = 1'b1;
            end
        end
        if (wr && ctl_q.unlocked && (addr == ADDR_PRESC)) begin
            ctl_d.prer = wdata[PRER_W-1:0];
        end
        if (wr && ctl_q.unlocked && (addr == ADDR_RELOAD)) begin
            ctl_d.reload = wdata[RELOAD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.unlocked <= 1'b0;
            ctl_q.running  <= 1'b0;
            ctl_q.prer     <= '0;
            ctl_q.reload   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign unlocked = ctl_q.unlocked;
    assign running  = ctl_q.running;
    assign prer     = ctl_q.prer;
    assign reload   = ctl_q.reload;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRER_W   = 3,
    parameter int BASE_LOG = 2,
    parameter int MAX_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              clear,
    input  logic [PRER_W-1:0] prer,
    output logic              step
);

    localparam int PC_W       = MAX_LOG;
    localparam int NUM_RATIOS = 2 ** PRER_W;

    typedef struct packed {
        logic [PC_W-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PC_W-1:0] limit;
    logic [PC_W-1:0] limit_tab [NUM_RATIOS];

    // one terminal-count value per prescaler code, fixed at elaboration
    for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_limit
        localparam int unsigned LG = div_log2(gi, BASE_LOG, MAX_LOG);
        assign limit_tab[gi] = PC_W'((64'd1 << LG) - 64'd1);
    end

    assign limit = limit_tab[prer];

    always_comb begin
        pre_d = pre_q;
        step  = 1'b0;
        if (clear) begin
            pre_d.phase = '0;
        end else if (run && tick) begin
            if (pre_q.phase >= limit) begin
                pre_d.phase = '0;
                step        = 1'b1;
            end else begin
                pre_d.phase = pre_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q.phase <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [RELOAD_W-1:0] reload,
    output logic [RELOAD_W-1:0] count,
    output logic                expire
);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic                req;
    } dc_t;

    dc_t dc_d, dc_q;

    always_comb begin
        dc_d     = dc_q;
        dc_d.req = 1'b0;
        if (load) begin
            dc_d.cnt = reload;
        end else if (step) begin
            // a count of 0 or 1 ends the period, so reload 0 acts as 1
            if (dc_q.cnt <= RELOAD_W'(1)) begin
                dc_d.req = 1'b1;
                dc_d.cnt = reload;
            end else begin
                dc_d.cnt = dc_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q.cnt <= '1;
            dc_q.req <= 1'b0;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign count  = dc_q.cnt;
    assign expire = dc_q.req;

endmodule

// File: rtl/wdt_indep.sv
module wdt_indep
    import wdt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PRER_W   = 3,
    parameter int RELOAD_W = 12,
    parameter int BASE_LOG = 2,
    parameter int MAX_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdt_reset_req
);

    localparam int RUN_BIT  = DATA_W - 1;
    localparam int OPEN_BIT = DATA_W - 2;

    logic                key_unlocked;
    logic                wdt_running;
    logic [PRER_W-1:0]   cfg_prer;
    logic [RELOAD_W-1:0] cfg_reload;
    logic                key_refresh;
    logic                key_start;
    logic                cnt_load;
    logic                pre_step;
    logic [RELOAD_W-1:0] cnt_val;

    wdt_keyctl #(
        .DATA_W  (DATA_W),
        .PRER_W  (PRER_W),
        .RELOAD_W(RELOAD_W)
    ) u_keyctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .unlocked  (key_unlocked),
        .running   (wdt_running),
        .prer      (cfg_prer),
        .reload    (cfg_reload),
        .refresh   (key_refresh),
        .start_load(key_start)
    );

    assign cnt_load = key_refresh | key_start;

    wdt_prescaler #(
        .PRER_W  (PRER_W),
        .BASE_LOG(BASE_LOG),
        .MAX_LOG (MAX_LOG)
    ) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .run  (wdt_running),
        .clear(cnt_load),
        .prer (cfg_prer),
        .step (pre_step)
    );

    wdt_downcnt #(
        .RELOAD_W(RELOAD_W)
    ) u_downcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .step  (pre_step),
        .reload(cfg_reload),
        .count (cnt_val),
        .expire(wdt_reset_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_PRESC:  reg_rdata[PRER_W-1:0]   = cfg_prer;
            ADDR_RELOAD: reg_rdata[RELOAD_W-1:0] = cfg_reload;
            ADDR_STATUS: begin
                reg_rdata[RELOAD_W-1:0] = cnt_val;
                reg_rdata[OPEN_BIT]     = key_unlocked;
                reg_rdata[RUN_BIT]      = wdt_running;
            end
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_indep_chk.sv
module wdt_indep_chk #(
    parameter int DATA_W   = 16,
    parameter int RELOAD_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr,
    input logic [1:0]          addr,
    input logic [DATA_W-1:0]   wdata,
    input logic                unlocked,
    input logic                running,
    input logic [RELOAD_W-1:0] reload,
    input logic [RELOAD_W-1:0] cnt,
    input logic                req
);

    // R2: the unlock code opens configuration on the next cycle
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0 && wdata == 16'h5555) |=> unlocked);

    // R3: any other key closes configuration
    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0 && wdata != 16'h5555) |=> !unlocked);

    // R3: a locked reload write changes nothing
    p_locked_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd2 && !unlocked) |=> $stable(reload));

    // R5: running never clears
    p_running_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R6: refresh copies the reload value into the counter
    p_refresh_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0 && wdata == 16'hAAAA) |=> (cnt == $past(reload)));

    // R8: the reset request lasts a single cycle
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R10: nothing expires while stopped
    p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !req);

    // R10: the counter holds while stopped unless a refresh writes it
    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(wr && addr == 2'd0)) |=> $stable(cnt));

endmodule

bind wdt_indep wdt_indep_chk #(
    .DATA_W  (DATA_W),
    .RELOAD_W(RELOAD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .unlocked(key_unlocked),
    .running (wdt_running),
    .reload  (cfg_reload),
    .cnt     (cnt_val),
    .req     (wdt_reset_req)
);

// File: tb/wdt_indep_bench.sv
`timescale 1ns/1ps
module wdt_indep_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        wdt_reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_indep u_wdt_indep (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .wdt_reset_req(wdt_reset_req)
    );

    function automatic int exp_ratio(input int p);
        int r;
        r = 4 << p;
        return (r > 256) ? 256 : r;
    endfunction

    function automatic logic [15:0] exp_status(input bit run, input bit open,
                                               input logic [11:0] c);
        return {run, open, 2'b00, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // n ticks with random idle gaps before each; counts early requests
    task automatic run_ticks(input int n, input int maxgap, output int early);
        early = 0;
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (wdt_reset_req) early++;
            end
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (i < n - 1 && wdt_reset_req) early++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int early;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rd(2'd3, d); check("R1 status", d, exp_status(0, 0, 12'hFFF));
        rd(2'd1, d); check("R1 prescaler", d, 16'h0);
        rd(2'd2, d); check("R1 reload", d, 16'h0FFF);
        check("R1 reset_req", wdt_reset_req, 0);
        rd(2'd0, d); check("R9 key reads zero", d, 16'h0);

        // R3 locked write dropped
        wr(2'd2, 16'h0123);
        rd(2'd2, d); check("R3 locked reload", d, 16'h0FFF);

        // R2 unlock and write with upper bits
        wr(2'd0, 16'h5555);
        rd(2'd3, d); check("R2 unlocked flag", d, exp_status(0, 1, 12'hFFF));
        wr(2'd2, 16'hF00A);
        rd(2'd2, d); check("R2 reload masked", d, 16'h000A);
        wr(2'd1, 16'h00FD);
        rd(2'd1, d); check("R2 prescaler masked", d, 16'h0005);

        // R3 other key relocks
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h0050);
        rd(2'd2, d); check("R3 relocked reload", d, 16'h000A);
        rd(2'd3, d); check("R3 lock flag", d, exp_status(0, 0, 12'hFFF));

        // R10 stopped ignores ticks
        run_ticks(60, 1, early);
        rd(2'd3, d); check("R10 counter frozen", d, exp_status(0, 0, 12'hFFF));
        check("R10 no request", early + int'(wdt_reset_req), 0);

        // R6 refresh while stopped; R3 refresh relocks
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        rd(2'd3, d); check("R6 R3 refresh stopped", d, exp_status(0, 0, 12'h00A));

        // configure ratio 4, reload 3, then start
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0003);
        wr(2'd0, 16'hCCCC);
        rd(2'd3, d); check("R4 start", d, exp_status(1, 0, 12'h003));

        // R7 decrement every 4 ticks, idle cycles ignored
        run_ticks(3, 0, early);
        rd(2'd3, d); check("R7 before step", d, exp_status(1, 0, 12'h003));
        run_ticks(1, 0, early);
        rd(2'd3, d); check("R7 first step", d, exp_status(1, 0, 12'h002));
        repeat (10) @(negedge clk);
        rd(2'd3, d); check("R7 idle hold", d, exp_status(1, 0, 12'h002));

        // R8 timeout after 12 ticks total
        run_ticks(8, 1, early);
        check("R8 no early req", early, 0);
        check("R8 req at timeout", wdt_reset_req, 1);
        @(negedge clk);
        check("R8 single pulse", wdt_reset_req, 0);
        rd(2'd3, d); check("R8 reload and run", d, exp_status(1, 0, 12'h003));

        // R5 writes cannot stop it
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0007);
        rd(2'd3, d); check("R5 still running", d[15], 1);

        // R4 start while running keeps counter
        run_ticks(4, 0, early);
        wr(2'd0, 16'hCCCC);
        rd(2'd3, d); check("R4 restart no load", d, exp_status(1, 0, 12'h002));

        // R6 refresh mid-phase clears phase: full 12 ticks needed
        run_ticks(2, 0, early);
        wr(2'd0, 16'hAAAA);
        rd(2'd3, d); check("R6 refresh load", d, exp_status(1, 0, 12'h003));
        run_ticks(12, 2, early);
        check("R6 no early req", early, 0);
        check("R6 req after full period", wdt_reset_req, 1);

        // R7 R8 random configurations
        for (int t = 0; t < 8; t++) begin
            int p;
            int r;
            int n;
            p = int'($urandom_range(0, 7));
            r = int'($urandom_range(0, 10));
            if (t == 0) begin p = 7; r = 0; end
            if (t == 1) begin p = 6; r = 1; end
            n = exp_ratio(p) * ((r == 0) ? 1 : r);
            @(negedge clk);
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(p) | 16'hFFF8);
            wr(2'd2, 16'(r) | 16'hF000);
            wr(2'd0, 16'hAAAA);
            run_ticks(n, 2, early);
            check("R8 random no early req", early, 0);
            check("R7 R8 random timeout", wdt_reset_req, 1);
            @(negedge clk);
            check("R8 random single pulse", wdt_reset_req, 0);
        end

        // R1 R5 reset is the only way back to stopped
        do_reset();
        rd(2'd3, d); check("R1 R5 stopped after reset", d, exp_status(0, 0, 12'hFFF));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule